// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block chooses the fastest DMA transfer mode that a host port and an attached drive can both use. It takes the mode-support words reported by the drive, the mode masks the host port allows, the cable type and the device kind, together with a requested upper limit. It returns a standard ATA transfer mode code, or zero when no DMA mode is usable. Mode codes follow the usual numbering: single-word DMA modes start at 0x10, multiword DMA modes at 0x20 and UltraDMA modes at 0x40, the low bits giving the mode number.

Three mode classes are considered, fastest first: UltraDMA, then multiword, then single-word. For each class a mask of usable modes is formed from the drive word, the host mask and the drive's field-valid flags. The first class whose base code the request reaches and whose mask is nonzero wins, and its highest usable mode is taken. The result is then capped at the requested code. A request is made by pulsing `start`; the inputs are sampled on that clock edge and the answer appears one cycle later with a one-cycle `mode_valid` pulse. The answer is held until the next request.

Top module: `dma_mode_select`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mode_valid` and `mode_out` are cleared to 0.
- R2: `mode_valid` is high in exactly the cycle after a cycle with `start` high; `mode_out` only changes on a `start` edge and otherwise holds its value even when inputs change.
- R3: Classes are tried in the order UltraDMA (base 0x40), multiword (base 0x20), single-word (base 0x10); a class is skipped when `req_mode` is below its base or its mask is zero.
- R4: The chosen code is the winning class base plus the bit index of the highest set bit of that class mask.
- R5: The UltraDMA mask is `host_udma & drv_udma` when `fv_word[2]` is 1 and zero otherwise.
- R6: When `req_mode` is above 0x42, the UltraDMA mask has any of bits 3 to 6 set and `cable80` is 0, the mask is cut down to its bits 0 to 2.
- R7: The multiword mask is `host_mwdma & drv_mwdma` when `fv_word[1]` is 1 and zero otherwise.
- R8: The single-word mask is `host_swdma & drv_swdma` when `fv_word[1]` is 1; otherwise, when `drv_legacy_sw` is 1 or 2, it is `host_swdma` with only bits 0 up to `drv_legacy_sw` kept, and zero for any other legacy value.
- R9: `mode_out` is the smaller of the chosen code and `req_mode`.
- R10: When `non_disk` and `host_no_atapi_dma` are both 1, `mode_out` is 0.
- R11: When no class qualifies, `mode_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe; inputs sampled on this edge |
| fv_word | input | 2 ([2:1]) | Drive field-valid flags: bit 2 UltraDMA word valid, bit 1 DMA words valid |
| drv_udma | input | 8 | Drive UltraDMA supported-mode bits |
| drv_mwdma | input | 8 | Drive multiword DMA supported-mode bits |
| drv_swdma | input | 8 | Drive single-word DMA supported-mode bits |
| drv_legacy_sw | input | 8 | Legacy single-word mode number from older drives |
| host_udma | input | 8 | Host-allowed UltraDMA modes |
| host_mwdma | input | 8 | Host-allowed multiword DMA modes |
| host_swdma | input | 8 | Host-allowed single-word DMA modes |
| cable80 | input | 1 | 1 when an 80-wire cable is detected |
| non_disk | input | 1 | 1 when the device is not a disk |
| host_no_atapi_dma | input | 1 | 1 when the host forbids DMA for non-disk devices |
| req_mode | input | 8 | Requested upper-limit mode code |
| mode_valid | output | 1 | One-cycle pulse marking a fresh result |
| mode_out | output | 8 | Selected mode code, 0 for no DMA |

## Verification
Every result is due exactly one clock after the edge that samples `start`, and the valid pulse must be gone one clock after that while the code stays put. The bench drives inputs on the falling edge, samples the first falling edge after the registering edge for the code and the pulse, then checks the following falling edge for pulse removal and a held code. The sweep crosses several drive and host patterns with all field-valid, cable and device-kind settings and a set of requested codes placed on and around each class boundary, computing each expected code arithmetically from the requirements.

// File: rtl/dmsel_pkg.sv
// Package: shared mode code type and class base codes for the DMA mode selector.
// Assumes the standard ATA transfer mode numbering (class base plus mode index).
package dmsel_pkg;
    typedef logic [7:0] mode_t;

    localparam mode_t SW_BASE   = 8'h10;
    localparam mode_t MW_BASE   = 8'h20;
    localparam mode_t UDMA_BASE = 8'h40;
    localparam int    NUM_CLASS = 3;

    // Class index in priority order: 0 fastest (UltraDMA), 2 slowest (single-word).
    function automatic mode_t class_base(input int cls);
        case (cls)
            0:       class_base = UDMA_BASE;
            1:       class_base = MW_BASE;
            default: class_base = SW_BASE;
        endcase
    endfunction
endpackage

// File: rtl/dmsel_masks.sv
// Module: forms the usable-mode mask of each DMA class from drive words, host
// masks and field-valid flags, applying the cable limit and legacy decoding.
// Assumes MASK_W <= 8 and that mask bit i stands for mode i of its class.
module dmsel_masks
    import dmsel_pkg::*;
#(
    parameter int MASK_W        = 8,
    parameter int UDMA_SLOW_N   = 3,
    parameter int UDMA_FAST_TOP = 6,
    parameter int LEGACY_MAX    = 2
) (
    input  logic [2:1]        fv_word,
    input  mode_t             req_mode,
    input  logic [MASK_W-1:0] drv_udma,
    input  logic [MASK_W-1:0] drv_mwdma,
    input  logic [MASK_W-1:0] drv_swdma,
    input  mode_t             drv_legacy_sw,
    input  logic [MASK_W-1:0] host_udma,
    input  logic [MASK_W-1:0] host_mwdma,
    input  logic [MASK_W-1:0] host_swdma,
    input  logic              cable80,
    output logic [MASK_W-1:0] udma_mask,
    output logic [MASK_W-1:0] mw_mask,
    output logic [MASK_W-1:0] sw_mask
);
    // Builds a mask with bits lo..hi set, clipped to the mask width.
    function automatic logic [MASK_W-1:0] span_mask(input int lo, input int hi);
        span_mask = '0;
        for (int i = 0; i < MASK_W; i++) begin
            if (i >= lo && i <= hi) span_mask[i] = 1'b1;
        end
    endfunction

    localparam logic [MASK_W-1:0] SLOW_KEEP   = span_mask(0, UDMA_SLOW_N - 1);
    localparam logic [MASK_W-1:0] FAST_BITS   = span_mask(UDMA_SLOW_N, UDMA_FAST_TOP);
    localparam mode_t             CABLE_LIMIT = UDMA_BASE + mode_t'(UDMA_SLOW_N - 1);

    logic [MASK_W-1:0] udma_raw;
    logic [MASK_W-1:0] legacy_mask;
    logic              legacy_ok;
    logic              cable_cut;

    // Raw UltraDMA mask, gated by the UltraDMA word-valid flag.
    assign udma_raw  = fv_word[2] ? (host_udma & drv_udma) : '0;
    // Cable limit applies only when fast modes are requested and present.
    assign cable_cut = (req_mode > CABLE_LIMIT) && |(udma_raw & FAST_BITS) && !cable80;

    // Final UltraDMA mask after the cable limit.
    always_comb begin
        udma_mask = cable_cut ? (udma_raw & SLOW_KEEP) : udma_raw;
    end

    // Multiword mask, gated by the DMA word-valid flag.
    assign mw_mask = fv_word[1] ? (host_mwdma & drv_mwdma) : '0;

    // Legacy single-word mode number is usable only in 1..LEGACY_MAX.
    assign legacy_ok = (drv_legacy_sw != '0) && (drv_legacy_sw <= mode_t'(LEGACY_MAX));

    // Legacy mode number decoded to a mask of all modes up to it.
    for (genvar g = 0; g < MASK_W; g++) begin : g_legacy
        if (g <= LEGACY_MAX) begin : g_live
            assign legacy_mask[g] = legacy_ok && (drv_legacy_sw >= mode_t'(g));
        end else begin : g_dead
            assign legacy_mask[g] = 1'b0;
        end
    end

    // Single-word mask: drive word when valid, otherwise decoded legacy field.
    always_comb begin
        if (fv_word[1]) sw_mask = host_swdma & drv_swdma;
        else            sw_mask = host_swdma & legacy_mask;
    end
endmodule

// File: rtl/dmsel_pick.sv
// Module: picks the first qualifying class in priority order, takes its highest
// mode, clamps to the request and blocks non-disk devices when told to.
// Assumes class masks arrive in priority order (UltraDMA, multiword, single-word).
module dmsel_pick
    import dmsel_pkg::*;
#(
    parameter int MASK_W = 8
) (
    input  logic [MASK_W-1:0] udma_mask,
    input  logic [MASK_W-1:0] mw_mask,
    input  logic [MASK_W-1:0] sw_mask,
    input  mode_t             req_mode,
    input  logic              atapi_block,
    output mode_t             sel_mode
);
    // Index of the highest set bit, 0 for an empty mask.
    function automatic mode_t top_bit(input logic [MASK_W-1:0] m);
        top_bit = '0;
        for (int i = 0; i < MASK_W; i++) begin
            if (m[i]) top_bit = mode_t'(i);
        end
    endfunction

    logic [MASK_W-1:0] cls_mask [NUM_CLASS];
    logic              cls_en   [NUM_CLASS];
    mode_t             cls_cand [NUM_CLASS];
    mode_t             raw_mode;

    assign cls_mask[0] = udma_mask;
    assign cls_mask[1] = mw_mask;
    assign cls_mask[2] = sw_mask;

    // Per-class qualification and candidate code.
    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
        localparam mode_t BASE = class_base(c);
        assign cls_en[c]   = (req_mode >= BASE) && (cls_mask[c] != '0);
        assign cls_cand[c] = BASE + top_bit(cls_mask[c]);
    end

    // Priority choice: first qualifying class in order wins.
    always_comb begin
        raw_mode = '0;
        for (int c = NUM_CLASS - 1; c >= 0; c--) begin
            if (cls_en[c]) raw_mode = cls_cand[c];
        end
    end

    // Clamp to the request, then apply the non-disk block.
    always_comb begin
        if (atapi_block)            sel_mode = '0;
        else if (raw_mode > req_mode) sel_mode = req_mode;
        else                        sel_mode = raw_mode;
    end
endmodule

// File: rtl/dma_mode_select.sv
// Module: top of the DMA transfer mode selector. Samples all inputs on a start
// strobe and registers the chosen mode code with a one-cycle valid pulse.
// Assumes inputs are stable at the clock edge where start is high.
module dma_mode_select
    import dmsel_pkg::*;
#(
    parameter int MASK_W        = 8,
    parameter int UDMA_SLOW_N   = 3,
    parameter int UDMA_FAST_TOP = 6,
    parameter int LEGACY_MAX    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:1]        fv_word,
    input  logic [MASK_W-1:0] drv_udma,
    input  logic [MASK_W-1:0] drv_mwdma,
    input  logic [MASK_W-1:0] drv_swdma,
    input  logic [7:0]        drv_legacy_sw,
    input  logic [MASK_W-1:0] host_udma,
    input  logic [MASK_W-1:0] host_mwdma,
    input  logic [MASK_W-1:0] host_swdma,
    input  logic              cable80,
    input  logic              non_disk,
    input  logic              host_no_atapi_dma,
    input  logic [7:0]        req_mode,
    output logic              mode_valid,
    output logic [7:0]        mode_out
);
    logic [MASK_W-1:0] udma_mask;
    logic [MASK_W-1:0] mw_mask;
    logic [MASK_W-1:0] sw_mask;
    mode_t             sel_mode;

    dmsel_masks #(
        .MASK_W        (MASK_W),
        .UDMA_SLOW_N   (UDMA_SLOW_N),
        .UDMA_FAST_TOP (UDMA_FAST_TOP),
        .LEGACY_MAX    (LEGACY_MAX)
    ) u_masks (
        .fv_word       (fv_word),
        .req_mode      (req_mode),
        .drv_udma      (drv_udma),
        .drv_mwdma     (drv_mwdma),
        .drv_swdma     (drv_swdma),
        .drv_legacy_sw (drv_legacy_sw),
        .host_udma     (host_udma),
        .host_mwdma    (host_mwdma),
        .host_swdma    (host_swdma),
        .cable80       (cable80),
        .udma_mask     (udma_mask),
        .mw_mask       (mw_mask),
        .sw_mask       (sw_mask)
    );

    dmsel_pick #(
        .MASK_W (MASK_W)
    ) u_pick (
        .udma_mask   (udma_mask),
        .mw_mask     (mw_mask),
        .sw_mask     (sw_mask),
        .req_mode    (req_mode),
        .atapi_block (non_disk && host_no_atapi_dma),
        .sel_mode    (sel_mode)
    );

    // Result register: capture on start, pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_valid <= 1'b0;
            mode_out   <= '0;
        end else begin
            mode_valid <= start;
            if (start) mode_out <= sel_mode;
        end
    end
endmodule

// File: rtl/dmsel_chk.sv
// Module: property checker for the DMA mode selector, attached by bind.
// Assumes the top's registered output timing of one cycle after start.
module dmsel_chk
    import dmsel_pkg::*;
#(
    parameter int MASK_W = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       non_disk,
    input logic       host_no_atapi_dma,
    input logic [7:0] req_mode,
    input logic       mode_valid,
    input logic [7:0] mode_out
);
    localparam mode_t SW_TOP   = SW_BASE + mode_t'(MASK_W - 1);
    localparam mode_t MW_TOP   = MW_BASE + mode_t'(MASK_W - 1);
    localparam mode_t UDMA_TOP = UDMA_BASE + mode_t'(MASK_W - 1);

    // R2: a start is answered by a valid pulse in the next cycle.
    p_valid_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> mode_valid);

    // R2: no valid pulse without a start in the previous cycle.
    p_no_stray_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !mode_valid);

    // R2: the result holds when no request is made.
    p_hold_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(mode_out));

    // R9: the result never exceeds the requested code.
    p_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (mode_out <= $past(req_mode)));

    // R10: blocked non-disk devices get no DMA.
    p_atapi_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && non_disk && host_no_atapi_dma) |=> (mode_out == 8'h00));

    // R4: a nonzero result lies inside one class range.
    p_class_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && mode_out != 8'h00) |->
            ((mode_out >= SW_BASE && mode_out <= SW_TOP) ||
             (mode_out >= MW_BASE && mode_out <= MW_TOP) ||
             (mode_out >= UDMA_BASE && mode_out <= UDMA_TOP)));
endmodule

bind dma_mode_select dmsel_chk #(.MASK_W(MASK_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .start             (start),
    .non_disk          (non_disk),
    .host_no_atapi_dma (host_no_atapi_dma),
    .req_mode          (req_mode),
    .mode_valid        (mode_valid),
    .mode_out          (mode_out)
);

// File: tb/dma_mode_select_tb.sv
// Bench: sweeps drive/host patterns, flags, cable, device kind and request codes,
// comparing against an arithmetic model of the requirements.
module dma_mode_select_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:1] fv_word = '0;
    logic [7:0] drv_udma = '0, drv_mwdma = '0, drv_swdma = '0, drv_legacy_sw = '0;
    logic [7:0] host_udma = '0, host_mwdma = '0, host_swdma = '0;
    logic       cable80 = 1'b0, non_disk = 1'b0, host_no_atapi_dma = 1'b0;
    logic [7:0] req_mode = '0;
    logic       mode_valid;
    logic [7:0] mode_out;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dma_mode_select u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fv_word(fv_word),
        .drv_udma(drv_udma), .drv_mwdma(drv_mwdma), .drv_swdma(drv_swdma),
        .drv_legacy_sw(drv_legacy_sw), .host_udma(host_udma),
        .host_mwdma(host_mwdma), .host_swdma(host_swdma), .cable80(cable80),
        .non_disk(non_disk), .host_no_atapi_dma(host_no_atapi_dma),
        .req_mode(req_mode), .mode_valid(mode_valid), .mode_out(mode_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int hi_idx(input logic [7:0] m);
        int r = 0;
        for (int i = 0; i < 8; i++) if (m[i]) r = i;
        return r;
    endfunction

    // Arithmetic model of R3..R11; also names the requirement the case exercises.
    function automatic int model(output string tag);
        logic [7:0] um, mm, sm;
        int m = 0;
        int req = int'(req_mode);
        tag = "R3 R4";
        if (non_disk && host_no_atapi_dma) begin
            tag = "R10";
            return 0;
        end
        if (req >= 'h40) begin
            um = fv_word[2] ? (host_udma & drv_udma) : 8'h00;   // R5
            if (req > 'h42 && (um & 8'h78) != 0 && !cable80) begin
                um = um & 8'h07;                                 // R6
                tag = "R6";
            end else tag = "R5";
            if (um != 0) m = 'h40 + hi_idx(um);
        end
        if (m == 0 && req >= 'h20) begin
            mm = fv_word[1] ? (host_mwdma & drv_mwdma) : 8'h00; // R7
            tag = "R7";
            if (mm != 0) m = 'h20 + hi_idx(mm);
        end
        if (m == 0 && req >= 'h10) begin
            if (fv_word[1]) sm = host_swdma & drv_swdma;        // R8
            else if (drv_legacy_sw == 1 || drv_legacy_sw == 2)
                sm = host_swdma & ((8'h02 << drv_legacy_sw) - 8'h01);
            else sm = 8'h00;
            tag = "R8";
            if (sm != 0) m = 'h10 + hi_idx(sm);
        end
        if (m == 0) begin
            tag = {tag, " R11"};
            return 0;
        end
        if (m > req) begin
            tag = {tag, " R9"};
            return req;
        end
        return m;
    endfunction

    function automatic logic [7:0] req_at(input int r);
        case (r)
            0: return 8'h00;  1: return 8'h0F;  2: return 8'h10;  3: return 8'h12;
            4: return 8'h1F;  5: return 8'h20;  6: return 8'h22;  7: return 8'h2F;
            8: return 8'h40;  9: return 8'h42; 10: return 8'h43; 11: return 8'h46;
            12: return 8'h47; default: return 8'hFF;
        endcase
    endfunction

    task automatic load_pattern(input int p);
        case (p)
            0: begin drv_udma=8'h7F; host_udma=8'h7F; drv_mwdma=8'h07; host_mwdma=8'h07;
                     drv_swdma=8'h07; host_swdma=8'h07; drv_legacy_sw=8'h00; end
            1: begin drv_udma=8'h3F; host_udma=8'h07; drv_mwdma=8'h04; host_mwdma=8'h07;
                     drv_swdma=8'h01; host_swdma=8'h07; drv_legacy_sw=8'h02; end
            2: begin drv_udma=8'h00; host_udma=8'hFF; drv_mwdma=8'h03; host_mwdma=8'h07;
                     drv_swdma=8'h04; host_swdma=8'h03; drv_legacy_sw=8'h01; end
            3: begin drv_udma=8'h80; host_udma=8'hFF; drv_mwdma=8'h00; host_mwdma=8'h07;
                     drv_swdma=8'h00; host_swdma=8'h07; drv_legacy_sw=8'h03; end
            4: begin drv_udma=8'h18; host_udma=8'hFF; drv_mwdma=8'h07; host_mwdma=8'h01;
                     drv_swdma=8'h00; host_swdma=8'h05; drv_legacy_sw=8'h02; end
            default: begin drv_udma=8'h00; host_udma=8'h00; drv_mwdma=8'h00; host_mwdma=8'h00;
                     drv_swdma=8'h00; host_swdma=8'h00; drv_legacy_sw=8'h00; end
        endcase
    endtask

    // One request: strobe, check result and pulse, then check pulse drop and hold.
    task automatic run_one;
        string tag;
        int exp;
        exp = model(tag);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " result"}, int'(mode_out), exp);
        check("R2 valid pulse", int'(mode_valid), 1);
        @(negedge clk);
        check("R2 valid drop", int'(mode_valid), 0);
        check("R2 hold", int'(mode_out), exp);
    endtask

    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid in reset", int'(mode_valid), 0);
        check("R1 mode in reset", int'(mode_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(mode_valid), 0);

        // R2: result holds while inputs move without a strobe
        load_pattern(0);
        fv_word = 2'b11; cable80 = 1'b1; req_mode = 8'hFF;
        run_one();
        held = int'(mode_out);
        req_mode = 8'h10; fv_word = 2'b00;
        repeat (3) @(negedge clk);
        check("R2 hold under input change", int'(mode_out), held);
        check("R2 no valid without strobe", int'(mode_valid), 0);

        // Sweep for R3..R11
        for (int p = 0; p < 6; p++) begin
            load_pattern(p);
            for (int f = 0; f < 4; f++) begin
                for (int cb = 0; cb < 2; cb++) begin
                    for (int g = 0; g < 4; g++) begin
                        for (int r = 0; r < 14; r++) begin
                            fv_word = f[1:0];
                            cable80 = cb[0];
                            non_disk = g[0];
                            host_no_atapi_dma = g[1];
                            req_mode = req_at(r);
                            run_one();
                        end
                    end
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule